// File: doc/BRIEF.md
# Compact Minifloat Adder

The block adds two numbers held in a ten-bit floating-point word and returns the sum in the same word. A word carries a sign in bit 9, a four-bit exponent in bits 8:5 stored with a bias of 7, and a five-bit fraction in bits 4:0 that sits behind an implied leading one. The two operands are aligned on the larger exponent and summed as signed mantissas, with one guard bit kept below the fraction. The sum is brought back to the 1.fffff form, then either truncated or rounded half-up on the guard bit. An exponent field of zero is reserved for the value zero. Results that would leave the exponent range saturate or flush.

Operands arrive on a valid/ready stream, and each accepted pair produces one result on an output valid/ready stream one cycle later. The block holds one result in a single output register. It accepts a new pair whenever that register is empty or is being drained in the same cycle. While the consumer stalls, the result stays frozen and the input side is closed. The rounding control is a plain pin that is sampled together with the operands.

Top module: `minifloat_adder`

## Requirements
- R1: A word is {sign[9], exponent[8:5], fraction[4:0]}, value (-1)^sign x 1.fraction x 2^(exponent-7); for example 0_1010_00101 plus 0_1001_00101 yields 0_1010_10111 with rounding off.
- R2: The mantissa of the operand with the smaller exponent is shifted right by the exponent difference before the add, keeping exactly one bit below the fraction as a guard; anything shifted further is lost, so a difference of 7 or more leaves the larger operand unchanged.
- R3: Operands of opposite sign are subtracted; the result sign is the sign of the operand with the larger magnitude.
- R4: A sum of 2.0 or more is shifted right by one with the exponent raised by one; a sum below 1.0 is shifted left until its leading one is in the hidden position, with the exponent lowered by the shift.
- R5: With round_en = 0 the guard bit is dropped (truncation).
- R6: With round_en = 1 and a guard bit of 1, one unit is added to the fraction; a carry out of the mantissa gives fraction 00000 and an exponent one higher.
- R7: An operand with exponent field 0 counts as zero whatever its fraction; a zero result, including exact cancellation, is the all-zero word with a positive sign.
- R8: A result exponent above 15 saturates to the word {sign, 1111, 11111}.
- R9: A result exponent below 1 flushes the result to the all-zero word.
- R10: A pair is accepted on a cycle with in_valid and in_ready both high; its result is presented with out_valid high from the next cycle on.
- R11: in_ready is high exactly when out_valid is low or out_ready is high; while out_valid is high and out_ready low, sum and out_valid hold.
- R12: After reset out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block takes the pair this cycle |
| op_a | input | 10 | First operand |
| op_b | input | 10 | Second operand |
| round_en | input | 1 | 1 = round half-up on guard, 0 = truncate |
| out_valid | output | 1 | Result is present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| sum | output | 10 | Result word |

## Verification
The bench aims at the points where the guard bit matters. An alignment that kept more than one extra bit would turn the two-bit shift case into a different rounded value. A design that forgot the carry on rounding would wrap 1.11111 up to 1.00000 at the same exponent. It also drives exact cancellation and mixed-sign pairs. A design that skipped the re-complement or took the sign from the wrong operand would output a negative zero or a flipped sign. Further cases drive both exponent limits, where a wrapping exponent shows up as a tiny or huge wrong value. Random stalls on the output exercise the hold rules, and any lost or duplicated result shows up as a scoreboard mismatch.

// File: rtl/mf_pkg.sv
package mf_pkg;
  typedef enum logic {RND_TRUNC = 1'b0, RND_HALF_UP = 1'b1} rnd_mode_e;

  // hidden one + fraction + one guard bit
  function automatic int mant_w(input int frac_w);
    return frac_w + 2;
  endfunction
endpackage

// File: rtl/mf_align.sv
module mf_align #(
  parameter int EXP_W  = 4,
  parameter int FRAC_W = 5
) (
  input  logic [EXP_W+FRAC_W:0]          op_a,
  input  logic [EXP_W+FRAC_W:0]          op_b,
  output logic [EXP_W-1:0]               exp_big,
  output logic [mf_pkg::mant_w(FRAC_W)-1:0] mant_big,
  output logic [mf_pkg::mant_w(FRAC_W)-1:0] mant_small,
  output logic                           sign_big,
  output logic                           sign_small
);
  localparam int MW = mf_pkg::mant_w(FRAC_W);
  localparam int W  = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0] ea, eb, diff;
  logic [MW-1:0]    ma, mb;
  logic             a_big;

  assign ea = op_a[W-2 -: EXP_W];
  assign eb = op_b[W-2 -: EXP_W];
  // exponent field zero encodes zero: no hidden one
  assign ma = (ea == '0) ? '0 : {1'b1, op_a[FRAC_W-1:0], 1'b0};
  assign mb = (eb == '0) ? '0 : {1'b1, op_b[FRAC_W-1:0], 1'b0};

  assign a_big      = (ea >= eb);
  assign diff       = a_big ? (ea - eb) : (eb - ea);
  assign exp_big    = a_big ? ea : eb;
  assign mant_big   = a_big ? ma : mb;
  assign mant_small = (a_big ? mb : ma) >> diff;
  assign sign_big   = a_big ? op_a[W-1] : op_b[W-1];
  assign sign_small = a_big ? op_b[W-1] : op_a[W-1];
endmodule

// File: rtl/mf_combine.sv
module mf_combine #(
  parameter int MW = 7
) (
  input  logic [MW-1:0] mant_x,
  input  logic [MW-1:0] mant_y,
  input  logic          sign_x,
  input  logic          sign_y,
  output logic [MW:0]   mag,
  output logic          sign_out
);
  localparam int SW = MW + 1;

  logic [SW:0] ext_x, ext_y, vx, vy, tot, absval;

  assign ext_x = {2'b00, mant_x};
  assign ext_y = {2'b00, mant_y};
  assign vx    = sign_x ? (~ext_x + 1'b1) : ext_x;
  assign vy    = sign_y ? (~ext_y + 1'b1) : ext_y;
  assign tot   = vx + vy;
  assign sign_out = tot[SW];
  assign absval   = tot[SW] ? (~tot + 1'b1) : tot;
  assign mag      = absval[SW-1:0];
endmodule

// File: rtl/mf_normalize.sv
module mf_normalize #(
  parameter int EXP_W  = 4,
  parameter int FRAC_W = 5
) (
  input  logic [FRAC_W+2:0]      mag,
  input  logic [EXP_W-1:0]       exp_big,
  input  logic                   sign_in,
  input  logic                   rnd_up,
  output logic [EXP_W+FRAC_W:0]  res
);
  localparam int MW   = mf_pkg::mant_w(FRAC_W);
  localparam int SW   = MW + 1;
  localparam int XW   = EXP_W + 2;
  localparam int LW   = $clog2(SW);
  localparam int EMAX = (1 << EXP_W) - 1;

  logic [LW-1:0]     lead;
  logic [XW-1:0]     shx, ex;
  logic [MW-1:0]     norm;
  logic [FRAC_W-1:0] frac;
  logic [FRAC_W+1:0] rsum;

  always_comb begin
    lead = '0;
    for (int i = 0; i < SW; i++) begin
      if (mag[i]) lead = LW'(i);
    end

    shx = XW'(MW - 1) - XW'(lead);
    if (mag[SW-1]) begin
      norm = mag[SW-1:1];
      ex   = {2'b00, exp_big} + XW'(1);
    end else begin
      norm = mag[MW-1:0] << shx;
      ex   = {2'b00, exp_big} - shx;
    end

    frac = norm[MW-2:1];
    rsum = {1'b0, 1'b1, frac} + (FRAC_W+2)'(1);
    if (rnd_up && norm[0]) begin
      if (rsum[FRAC_W+1]) begin
        frac = '0;
        ex   = ex + XW'(1);
      end else begin
        frac = rsum[FRAC_W-1:0];
      end
    end

    if (mag == '0)
      res = '0;
    else if (!ex[XW-1] && (ex > XW'(EMAX)))
      res = {sign_in, {EXP_W{1'b1}}, {FRAC_W{1'b1}}};
    else if (ex[XW-1] || (ex == '0))
      res = '0;
    else
      res = {sign_in, ex[EXP_W-1:0], frac};
  end
endmodule

// File: rtl/minifloat_adder.sv
module minifloat_adder #(
  parameter int EXP_W  = 4,
  parameter int FRAC_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  logic                  round_en,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [EXP_W+FRAC_W:0] sum
);
  import mf_pkg::*;
  localparam int MW = mant_w(FRAC_W);
  localparam int W  = 1 + EXP_W + FRAC_W;

  logic [EXP_W-1:0] exp_big;
  logic [MW-1:0]    mant_big, mant_small;
  logic             sign_big, sign_small, sign_sum;
  logic [MW:0]      mag;
  logic [W-1:0]     res;
  rnd_mode_e        mode;

  assign mode = rnd_mode_e'(round_en);

  mf_align #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_align (
    .op_a(op_a), .op_b(op_b), .exp_big(exp_big),
    .mant_big(mant_big), .mant_small(mant_small),
    .sign_big(sign_big), .sign_small(sign_small)
  );

  mf_combine #(.MW(MW)) u_combine (
    .mant_x(mant_big), .mant_y(mant_small),
    .sign_x(sign_big), .sign_y(sign_small),
    .mag(mag), .sign_out(sign_sum)
  );

  mf_normalize #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_norm (
    .mag(mag), .exp_big(exp_big), .sign_in(sign_sum),
    .rnd_up(mode == RND_HALF_UP), .res(res)
  );

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sum       <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) sum <= res;
    end
  end
endmodule

// File: rtl/mf_adder_checker.sv
module mf_adder_checker #(
  parameter int EXP_W  = 4,
  parameter int FRAC_W = 5
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [EXP_W+FRAC_W:0] sum
);
  localparam int W = 1 + EXP_W + FRAC_W;

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(sum));

  p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_zero_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (sum[W-2 -: EXP_W] == '0) |-> (sum == '0));

  p_zero_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (op_a[W-2 -: EXP_W] == '0) && (op_b[W-2 -: EXP_W] == '0)
    |=> (sum == '0));
endmodule

bind minifloat_adder mf_adder_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
  .sum(sum)
);

// File: tb/sim_minifloat_adder.sv
module sim_minifloat_adder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, round_en = 1'b0, out_ready = 1'b1;
  logic [9:0] op_a = '0, op_b = '0;
  logic in_ready, out_valid;
  logic [9:0] sum;

  int checks = 0, fails = 0;
  logic [9:0] q_exp[$];
  string      q_tag[$];

  always #5 clk = ~clk;

  minifloat_adder u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .round_en(round_en),
    .out_valid(out_valid), .out_ready(out_ready), .sum(sum)
  );

  // independent arithmetic model written from the requirements
  function automatic logic [9:0] model_sum(input logic [9:0] a, input logic [9:0] b,
                                           input logic rnd);
    int ea, eb, ma, mb, el, va, vb, s, mag, e, m6, g;
    logic sg;
    ea = int'(a[8:5]); eb = int'(b[8:5]);
    ma = (ea == 0) ? 0 : (32 + int'(a[4:0])) * 2;
    mb = (eb == 0) ? 0 : (32 + int'(b[4:0])) * 2;
    if (ea >= eb) begin el = ea; mb = mb >> (ea - eb); end
    else          begin el = eb; ma = ma >> (eb - ea); end
    va = a[9] ? -ma : ma;
    vb = b[9] ? -mb : mb;
    s = va + vb;
    sg = (s < 0);
    mag = sg ? -s : s;
    if (mag == 0) return 10'd0;
    e = el;
    while (mag >= 128) begin mag = mag >> 1; e++; end
    while (mag < 64)   begin mag = mag << 1; e--; end
    g  = mag % 2;
    m6 = mag / 2;
    if (rnd && g == 1) begin
      m6++;
      if (m6 == 64) begin m6 = 32; e++; end
    end
    if (e > 15) return {sg, 4'hF, 5'h1F};
    if (e < 1)  return 10'd0;
    return {sg, 4'(e), 5'(m6)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [9:0] a, input logic [9:0] b, input logic rnd,
                      input logic [9:0] exp, input string tag);
    op_a = a; op_b = b; round_en = rnd; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      out_ready = 1'b1;
      #1;
    end
    q_exp.push_back(exp);
    q_tag.push_back(tag);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (q_exp.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10: result %0h with nothing expected", sum);
      end else begin
        check(q_tag.pop_front(), 32'(sum), 32'(q_exp.pop_front()));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R12 out_valid after reset", 32'(out_valid), 32'd0);
    check("R12 in_ready after reset", 32'(in_ready), 32'd1);
    @(negedge clk);

    send(10'b0_1010_00101, 10'b0_1001_00101, 1'b0, 10'b0_1010_10111, "R1 R5 example");
    send(10'b0_1010_00101, 10'b0_1001_00101, 1'b1, 10'b0_1010_11000, "R6 example rounded");
    send(10'b0_0101_00000, 10'b0_0011_00011, 1'b0, 10'b0_0101_01000, "R2 guard truncate");
    send(10'b0_0101_00000, 10'b0_0011_00011, 1'b1, 10'b0_0101_01001, "R2 guard rounded");
    send(10'b0_1100_00001, 10'b0_0100_11111, 1'b1, 10'b0_1100_00001, "R2 wide shift");
    send(10'b0_1000_00000, 10'b1_0111_10000, 1'b0, 10'b0_0110_00000, "R3 R4 positive diff");
    send(10'b1_1000_00000, 10'b0_0111_10000, 1'b0, 10'b1_0110_00000, "R3 negative diff");
    send(10'b0_0011_11111, 10'b0_0010_00001, 1'b0, 10'b0_0100_00111, "R4 carry trunc");
    send(10'b0_0011_11111, 10'b0_0010_00001, 1'b1, 10'b0_0100_01000, "R4 carry rounded");
    send(10'b0_0111_11111, 10'b0_0001_00000, 1'b0, 10'b0_0111_11111, "R5 no round");
    send(10'b0_0111_11111, 10'b0_0001_00000, 1'b1, 10'b0_1000_00000, "R6 round carry");
    send(10'b0_0110_10000, 10'b1_0110_10000, 1'b0, 10'b0_0000_00000, "R7 cancel");
    send(10'b1_0110_10000, 10'b0_0110_10000, 1'b1, 10'b0_0000_00000, "R7 cancel swapped");
    send(10'b0_0000_00000, 10'b1_0100_01010, 1'b0, 10'b1_0100_01010, "R7 zero operand");
    send(10'b0_0000_11111, 10'b0_0011_00100, 1'b0, 10'b0_0011_00100, "R7 exp zero frac");
    send(10'b0_1111_10000, 10'b0_1111_10000, 1'b0, 10'b0_1111_11111, "R8 pos saturate");
    send(10'b1_1111_10000, 10'b1_1111_10000, 1'b1, 10'b1_1111_11111, "R8 neg saturate");
    send(10'b0_0001_00001, 10'b1_0001_00000, 1'b0, 10'b0_0000_00000, "R9 flush");

    // back-pressure: hold the result, close the input
    @(negedge clk);
    out_ready = 1'b0;
    send(10'b0_1001_00011, 10'b0_1001_00001, 1'b0, 10'b0_1010_00010, "R10 R11 stalled result");
    repeat (3) @(negedge clk);
    #1;
    check("R11 out_valid held", 32'(out_valid), 32'd1);
    check("R11 sum held", 32'(sum), 32'(10'b0_1010_00010));
    check("R11 in_ready low", 32'(in_ready), 32'd0);
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 300; i++) begin
      logic [9:0] a, b;
      logic r;
      a = 10'($urandom);
      b = 10'($urandom);
      r = 1'($urandom);
      out_ready = ($urandom % 4) != 0;
      send(a, b, r, model_sum(a, b, r), "R3 R4 R6 random");
    end
    out_ready = 1'b1;

    while (q_exp.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule